// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Receiver

This block turns the demodulated output of an infrared receiver into decoded remote-control words. The raw pin passes through a flip-flop chain whose length is a parameter. It is then corrected for polarity, so that one level always means "mark" (carrier present). The time between transitions is measured in pulses of an external strobe. That strobe runs at eight times the base 562.5 µs unit.

A decoding state machine recognises two kinds of transmission. The first is a full frame: a long leader, 32 pulse-distance bits and a closing mark. The second is the short repeat code that a remote sends while a key is held. A full frame is reported only when its address and command bytes each match the bitwise inverse that follows them. A repeat code re-reports the last accepted address and command, with a flag set. The result goes out as a 17-bit word with a one-cycle write strobe, which suits a FIFO write port or an event register. Any timing that falls outside the allowed windows sends the decoder back to idle without writing anything.

Top module: `ir_pd_receiver`

## Requirements
- R1: With `invert_pol`=0 a high pin level is a mark; with `invert_pol`=1 a low pin level is a mark. Frames are decoded identically under either setting.
- R2: Durations are counted in strobe pulses, with one unit equal to `UNIT_TICKS` (8) pulses. A duration of nominal count n is accepted from n-n/4 to n+n/4 inclusive. A mark or space outside its window returns the decoder to idle and writes nothing.
- R3: A frame is a 16-unit mark, an 8-unit space, 32 bits and a closing 1-unit mark. Each bit is a 1-unit mark followed by a 1-unit space for 0 or a 3-unit space for 1. The bits arrive least significant bit first, as four bytes in this order: address, inverted address, command, inverted command.
- R4: After reset `result_valid` is 0 and `result_word` is 0. Each result is written as a single-cycle `result_valid` pulse, issued after the falling edge of the closing mark. The word holds the address in [7:0], the command in [15:8] and the repeat flag in bit 16, which is 0 for a frame.
- R5: A frame is written only if the address equals the bitwise inverse of the second byte and the command equals the bitwise inverse of the fourth byte. A rejected frame does not change the stored last frame.
- R6: A repeat code is a 16-unit mark, a 4-unit space and a 1-unit mark. When `repeat_enable` is 1 and a frame has been accepted since reset, it writes the last accepted address and command with bit 16 set to 1.
- R7: A repeat code writes nothing when `repeat_enable` is 0 or when no frame has been accepted since reset.
- R8: A space that reaches 16 units (128 pulses) after the leader mark or during bit reception returns the decoder to idle at once, so that a leader starting after that space is decoded.
- R9: While `rx_enable` is 0 the decoder is held idle and writes nothing. The last accepted frame is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_enable | input | 1 | Decoder enable |
| invert_pol | input | 1 | 1: a low pin level is a mark |
| repeat_enable | input | 1 | 1: report repeat codes |
| ir_pin | input | 1 | Asynchronous demodulated IR input |
| strobe | input | 1 | One-cycle pulse every 1/8 unit |
| result_valid | output | 1 | One-cycle write strobe for `result_word` |
| result_word | output | 17 | {repeat flag, command, address} |

## Verification
A wrong decoder state shows up at the ports in one of two ways: a missing write, or a write with the wrong word or flag. The window to observe it is one transmission, since every frame or repeat code ends with either one write or none. A state machine that hangs in a space state is exposed by the timeout test: the frame that follows the long space goes missing. A stale or corrupted last-frame register appears in the payload of the next repeat write. A bad window bound either drops a frame sent with skewed but legal timing, or admits a frame whose spaces fall between the bit windows.

// File: rtl/ir_pd_pkg.sv
package ir_pd_pkg;

    // Durations in base units (one unit = UNIT_TICKS strobe pulses)
    localparam int U_LEAD_MARK  = 16;
    localparam int U_FRAME_GAP  = 8;
    localparam int U_REPEAT_GAP = 4;
    localparam int U_BIT_MARK   = 1;
    localparam int U_ZERO_GAP   = 1;
    localparam int U_ONE_GAP    = 3;
    localparam int U_TIMEOUT    = 16;

    localparam int FRAME_BITS   = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_MARK,
        ST_LEAD_SPACE,
        ST_BIT_MARK,
        ST_BIT_SPACE,
        ST_REP_MARK
    } dec_state_t;

    typedef struct packed {
        logic       repeat_flag;
        logic [7:0] command;
        logic [7:0] address;
    } ir_result_t;

    // +/-25% acceptance window around a nominal count
    function automatic logic in_window(input int count, input int nominal);
        int lo;
        int hi;
        lo = nominal - nominal / 4;
        hi = nominal + nominal / 4;
        return (count >= lo) && (count <= hi);
    endfunction

    // Both bytes must match their inverted partners
    function automatic logic frame_intact(input logic [FRAME_BITS-1:0] raw);
        return (raw[7:0] == ~raw[15:8]) && (raw[23:16] == ~raw[31:24]);
    endfunction

endpackage

// File: rtl/ir_pd_sync.sv
module ir_pd_sync
    import ir_pd_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic invert,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              level;
    logic              level_d;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign level = chain[STAGES-1] ^ invert;

    always_ff @(posedge clk) begin
        if (rst) level_d <= 1'b0;
        else     level_d <= level;
    end

    assign rise = level & ~level_d;
    assign fall = ~level & level_d;

endmodule

// File: rtl/ir_pd_timer.sv
module ir_pd_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             strobe,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (strobe && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ir_pd_decoder.sv
module ir_pd_decoder
    import ir_pd_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int UNIT_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             repeat_en,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] count,
    output logic             valid,
    output ir_result_t       word
);

    localparam int N_LEAD_MARK  = U_LEAD_MARK  * UNIT_TICKS;
    localparam int N_FRAME_GAP  = U_FRAME_GAP  * UNIT_TICKS;
    localparam int N_REPEAT_GAP = U_REPEAT_GAP * UNIT_TICKS;
    localparam int N_BIT_MARK   = U_BIT_MARK   * UNIT_TICKS;
    localparam int N_ZERO_GAP   = U_ZERO_GAP   * UNIT_TICKS;
    localparam int N_ONE_GAP    = U_ONE_GAP    * UNIT_TICKS;
    localparam int N_TIMEOUT    = U_TIMEOUT    * UNIT_TICKS;
    localparam int IDX_W        = $clog2(FRAME_BITS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS);

    dec_state_t              state;
    logic [IDX_W-1:0]        bit_idx;
    logic [FRAME_BITS-1:0]   shreg;
    logic [15:0]             last_payload;
    logic                    have_last;

    int   cnt_i;
    logic ok_lead, ok_frame_gap, ok_rep_gap, ok_mark, ok_zero, ok_one, timed_out;

    always_comb begin
        cnt_i        = int'(count);
        ok_lead      = in_window(cnt_i, N_LEAD_MARK);
        ok_frame_gap = in_window(cnt_i, N_FRAME_GAP);
        ok_rep_gap   = in_window(cnt_i, N_REPEAT_GAP);
        ok_mark      = in_window(cnt_i, N_BIT_MARK);
        ok_zero      = in_window(cnt_i, N_ZERO_GAP);
        ok_one       = in_window(cnt_i, N_ONE_GAP);
        timed_out    = cnt_i >= N_TIMEOUT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            bit_idx      <= '0;
            shreg        <= '0;
            last_payload <= '0;
            have_last    <= 1'b0;
            valid        <= 1'b0;
            word         <= '0;
        end else begin
            valid <= 1'b0;
            if (!enable) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (rise) state <= ST_LEAD_MARK;
                    end
                    ST_LEAD_MARK: begin
                        if (fall) state <= ok_lead ? ST_LEAD_SPACE : ST_IDLE;
                    end
                    ST_LEAD_SPACE: begin
                        if (rise) begin
                            if (ok_frame_gap) begin
                                state   <= ST_BIT_MARK;
                                bit_idx <= '0;
                            end else if (ok_rep_gap) begin
                                state <= ST_REP_MARK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (timed_out) begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_BIT_MARK: begin
                        if (fall) begin
                            if (!ok_mark) begin
                                state <= ST_IDLE;
                            end else if (bit_idx == LAST_IDX) begin
                                state <= ST_IDLE;
                                if (frame_intact(shreg)) begin
                                    valid        <= 1'b1;
                                    word         <= '{repeat_flag: 1'b0,
                                                      command: shreg[23:16],
                                                      address: shreg[7:0]};
                                    last_payload <= {shreg[23:16], shreg[7:0]};
                                    have_last    <= 1'b1;
                                end
                            end else begin
                                state <= ST_BIT_SPACE;
                            end
                        end
                    end
                    ST_BIT_SPACE: begin
                        if (rise) begin
                            if (ok_zero || ok_one) begin
                                shreg   <= {ok_one, shreg[FRAME_BITS-1:1]};
                                bit_idx <= bit_idx + 1'b1;
                                state   <= ST_BIT_MARK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (timed_out) begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_REP_MARK: begin
                        if (fall) begin
                            state <= ST_IDLE;
                            if (ok_mark && have_last && repeat_en) begin
                                valid <= 1'b1;
                                word  <= '{repeat_flag: 1'b1,
                                           command: last_payload[15:8],
                                           address: last_payload[7:0]};
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/ir_pd_receiver.sv
module ir_pd_receiver
    import ir_pd_pkg::*;
#(
    parameter int SYNC_STAGES = 3,
    parameter int UNIT_TICKS  = 8,
    parameter int CNT_W       = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_enable,
    input  logic        invert_pol,
    input  logic        repeat_enable,
    input  logic        ir_pin,
    input  logic        strobe,
    output logic        result_valid,
    output logic [16:0] result_word
);

    logic             edge_rise;
    logic             edge_fall;
    logic             cnt_clear;
    logic [CNT_W-1:0] dur_count;
    ir_result_t       dec_word;

    ir_pd_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin    (ir_pin),
        .invert (invert_pol),
        .rise   (edge_rise),
        .fall   (edge_fall)
    );

    assign cnt_clear = edge_rise | edge_fall | ~rx_enable;

    ir_pd_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (cnt_clear),
        .strobe (strobe),
        .count  (dur_count)
    );

    ir_pd_decoder #(
        .CNT_W      (CNT_W),
        .UNIT_TICKS (UNIT_TICKS)
    ) u_decoder (
        .clk       (clk),
        .rst       (rst),
        .enable    (rx_enable),
        .repeat_en (repeat_enable),
        .rise      (edge_rise),
        .fall      (edge_fall),
        .count     (dur_count),
        .valid     (result_valid),
        .word      (dec_word)
    );

    assign result_word = dec_word;

endmodule

// File: rtl/ir_pd_receiver_checker.sv
module ir_pd_receiver_checker (
    input logic        clk,
    input logic        rst,
    input logic        rx_enable,
    input logic        repeat_enable,
    input logic        result_valid,
    input logic [16:0] result_word
);

    logic [15:0] seen_payload;
    logic        seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_payload <= '0;
            seen_frame   <= 1'b0;
        end else if (result_valid && !result_word[16]) begin
            seen_payload <= result_word[15:0];
            seen_frame   <= 1'b1;
        end
    end

    // R4: write strobe is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R9: nothing is written in the cycle after a disabled cycle
    a_r9_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_enable) |-> !result_valid);

    // R7: a repeat write needs repeat reporting enabled
    a_r7_repeat_gated: assert property (@(posedge clk) disable iff (rst)
        (result_valid && result_word[16]) |-> $past(repeat_enable));

    // R6: a repeat write carries the last written frame payload
    a_r6_repeat_payload: assert property (@(posedge clk) disable iff (rst)
        (result_valid && result_word[16]) |-> (seen_frame && result_word[15:0] == seen_payload));

endmodule

bind ir_pd_receiver ir_pd_receiver_checker u_checker (
    .clk           (clk),
    .rst           (rst),
    .rx_enable     (rx_enable),
    .repeat_enable (repeat_enable),
    .result_valid  (result_valid),
    .result_word   (result_word)
);

// File: tb/ir_pd_receiver_bench.sv
module ir_pd_receiver_bench;

    localparam int DIV = 4;   // clocks per strobe pulse

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_enable = 1'b0;
    logic        invert_pol = 1'b0;
    logic        repeat_enable = 1'b0;
    logic        ir_pin = 1'b0;
    logic        strobe = 1'b0;
    logic        result_valid;
    logic [16:0] result_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    // behavioural model of the last accepted frame
    logic [15:0] model_last = '0;
    bit          model_have = 0;

    always #5 clk = ~clk;

    ir_pd_receiver u_ir_pd_receiver (
        .clk           (clk),
        .rst           (rst),
        .rx_enable     (rx_enable),
        .invert_pol    (invert_pol),
        .repeat_enable (repeat_enable),
        .ir_pin        (ir_pin),
        .strobe        (strobe),
        .result_valid  (result_valid),
        .result_word   (result_word)
    );

    initial begin
        forever begin
            for (int k = 0; k < DIV; k++) begin
                @(negedge clk);
                strobe = (k == DIV - 1);
            end
        end
    end

    // every-clock comparison against the expectation queue
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && result_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R5/R7/R9 unexpected write: actual %h expected no write", result_word);
                end else begin
                    logic [16:0] e;
                    string       t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (result_word !== e) begin
                        errors++;
                        $display("FAIL %s word: actual %h expected %h", t, result_word, e);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired (R1 to R9 run incomplete): actual hung expected done");
        finish_run();
    end

    task automatic hold(input logic mark, input int pulses);
        ir_pin = mark ^ invert_pol;
        repeat (pulses * DIV) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] c,
                              input logic [31:0] flip,
                              input int lm, input int ls, input int bm,
                              input int zs, input int os);
        logic [31:0] raw;
        raw = {~c, c, ~a, a} ^ flip;
        hold(1'b1, lm);
        hold(1'b0, ls);
        for (int i = 0; i < 32; i++) begin
            hold(1'b1, bm);
            hold(1'b0, raw[i] ? os : zs);
        end
        hold(1'b1, bm);
        hold(1'b0, 200);
    endtask

    task automatic send_std(input logic [7:0] a, input logic [7:0] c, input logic [31:0] flip);
        send_frame(a, c, flip, 128, 64, 8, 8, 24);
    endtask

    task automatic send_repeat();
        hold(1'b1, 128);
        hold(1'b0, 32);
        hold(1'b1, 8);
        hold(1'b0, 200);
    endtask

    task automatic expect_frame(input logic [7:0] a, input logic [7:0] c, input string t);
        exp_q.push_back({1'b0, c, a});
        tag_q.push_back(t);
        model_last = {c, a};
        model_have = 1;
    endtask

    task automatic expect_repeat(input string t);
        if (model_have && repeat_enable && rx_enable) begin
            exp_q.push_back({1'b1, model_last});
            tag_q.push_back(t);
        end
    endtask

    task automatic drain(input string t);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing write: actual none expected %h", t, exp_q[0]);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (result_valid !== 1'b0 || result_word !== 17'h0) begin
            errors++;
            $display("FAIL R4 reset: actual %b/%h expected 0/00000", result_valid, result_word);
        end
        rst = 1'b0;
        rx_enable = 1'b1;
        repeat (10) @(negedge clk);
        checks++;
        if (result_valid !== 1'b0 || result_word !== 17'h0) begin
            errors++;
            $display("FAIL R4 after reset: actual %b/%h expected 0/00000", result_valid, result_word);
        end

        // R7: repeat before any accepted frame
        repeat_enable = 1'b1;
        send_repeat();
        drain("R7 no prior frame");

        // R3 / R4: plain frames
        expect_frame(8'h5A, 8'h3C, "R3 frame 5A/3C");
        send_std(8'h5A, 8'h3C, 32'h0);
        drain("R3 frame 5A/3C");

        // R6: repeat returns last frame
        expect_repeat("R6 repeat after 5A/3C");
        send_repeat();
        drain("R6 repeat after 5A/3C");

        // R7: repeat reporting disabled
        repeat_enable = 1'b0;
        send_repeat();
        drain("R7 repeat disabled");
        repeat_enable = 1'b1;

        expect_frame(8'h00, 8'hFF, "R3 frame 00/FF");
        send_std(8'h00, 8'hFF, 32'h0);
        drain("R3 frame 00/FF");

        // R5: broken inverse in address and in command
        send_std(8'h12, 8'h34, 32'h0000_0100);
        drain("R5 bad address inverse");
        send_std(8'h12, 8'h34, 32'h8000_0000);
        drain("R5 bad command inverse");
        expect_repeat("R5 R6 last frame kept");
        send_repeat();
        drain("R5 R6 last frame kept");

        // R1: inverted polarity
        invert_pol = 1'b1;
        ir_pin = 1'b1;
        repeat (40) @(negedge clk);
        expect_frame(8'hA5, 8'hC3, "R1 inverted polarity");
        send_std(8'hA5, 8'hC3, 32'h0);
        drain("R1 inverted polarity");
        invert_pol = 1'b0;
        ir_pin = 1'b0;
        repeat (40) @(negedge clk);

        // R2: skewed but legal timing accepted
        expect_frame(8'h81, 8'h7E, "R2 skewed timing accepted");
        send_frame(8'h81, 8'h7E, 32'h0, 140, 56, 7, 9, 21);
        drain("R2 skewed timing accepted");

        // R2: leader mark too short
        send_frame(8'h11, 8'h22, 32'h0, 88, 64, 8, 8, 24);
        drain("R2 short leader rejected");

        // R2: bit space between the 0 and 1 windows
        send_frame(8'h11, 8'h22, 32'h0, 128, 64, 8, 8, 14);
        drain("R2 bit space out of window");

        // R8: long space mid-frame, then a fresh frame
        hold(1'b1, 128);
        hold(1'b0, 64);
        for (int i = 0; i < 5; i++) begin
            hold(1'b1, 8);
            hold(1'b0, 8);
        end
        hold(1'b1, 8);
        hold(1'b0, 160);
        expect_frame(8'h3F, 8'h09, "R8 timeout then frame");
        send_std(8'h3F, 8'h09, 32'h0);
        drain("R8 timeout then frame");

        // R9: disabled receiver ignores a frame, keeps last frame
        rx_enable = 1'b0;
        send_std(8'h44, 8'h55, 32'h0);
        drain("R9 disabled frame");
        rx_enable = 1'b1;
        repeat (20) @(negedge clk);
        expect_repeat("R9 R6 last frame after enable");
        send_repeat();
        drain("R9 R6 last frame after enable");

        finish_run();
    end

endmodule